// File: doc/BRIEF.md
# Relocatable peripheral window decoder

This block decides whether a bus address falls inside a peripheral window and, if it does, where in the window it lands. The window is one quarter of a 32-bit address map, 1 Gbyte in size, and it can sit at any of the four 1-Gbyte boundaries. A single control register holds the window base and an enable flag. That register is itself mapped at offset zero inside the window it defines, so writing a new base moves the register as well. Software has to follow the move and use the new address from then on.

A second register in the window holds a base address for a module-side local memory. The block stores this value and returns it on reads, but does not act on it. Out of reset the window is enabled at 0x4000_0000. The register bus is synchronous: writes take effect at the clock edge. Read data, the hit flag and the in-window offset are combinational from the current address.

Top module: `relwin_top`

## Requirements
- R1: After synchronous reset the control register holds base 2'b01 with the enable bit (bit 0) set, so a read at 0x4000_0000 returns 0x4000_0001. The memory-base register reads 0.
- R2: `win_hit` is 1 exactly when the enable bit is 1 and `bus_addr[31:30]` equals the stored base. Otherwise it is 0.
- R3: While `win_hit` is 1, `win_offset` equals `bus_addr[29:0]`.
- R4: A read at window offset 0 returns the base in bits 31:30, the enable bit in bit 0, and zero in bits 29:1. Written values in bits 29:1 are dropped.
- R5: A write at offset 0 of the current window loads base and enable from `bus_wdata[31:30]` and `bus_wdata[0]`. The change takes effect from the next cycle: the new address hits and the old one no longer does.
- R6: With the enable bit at 0 no address hits, including the control register's old address. Reads there return 0 and writes there change nothing.
- R7: The memory-base register at window offset 0x008 stores all 32 written bits, reads them back, and keeps its value when the window moves.
- R8: Inside the window, an offset other than 0x000 and 0x008 reads as 0, and writing it changes no register.
- R9: An access outside the window reads as 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Register bus address, also the decoded address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, 0 when no register is selected |
| win_hit | output | 1 | Address falls inside the enabled window |
| win_offset | output | 30 | Offset of the address within the window |

## Verification
The bench builds the block with its defaults: a 32-bit address with two window-select bits, reset base 1, the enable bit set, and the memory-base register at offset 0x008. With these values a short vector walk can reach all four window positions. The walk relocates the window from 0x4000_0000 to 0xC000_0000 and then to 0x0000_0000, and checks that each old address stops hitting. Separate tests disable the window through its own register and then write at the dead address, to show that an invalid window cannot re-enable itself. They also cover the offset output at the top of the window and a second reset after relocation.

// File: rtl/relwin_pkg.sv
package relwin_pkg;
    // Address map geometry
    localparam int ADDR_W = 32;
    localparam int SEL_W  = 2;
    localparam int OFF_W  = ADDR_W - SEL_W;
    localparam int DATA_W = 32;

    // Which register (if any) an access selects
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_CTRL = 2'd1,
        REG_MBAR = 2'd2,
        REG_HOLE = 2'd3
    } regsel_e;

    // Control register contents that are actually stored
    typedef struct packed {
        logic [SEL_W-1:0] base;
        logic             en;
    } win_ctrl_t;

    // Control register as seen on the bus: base at top, enable at bit 0
    function automatic logic [DATA_W-1:0] ctrl_to_word(input win_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1 -: SEL_W] = c.base;
        w[0] = c.en;
        return w;
    endfunction

    // Bus word to stored control contents; reserved bits dropped
    function automatic win_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        win_ctrl_t c;
        c.base = w[DATA_W-1 -: SEL_W];
        c.en   = w[0];
        return c;
    endfunction
endpackage

// File: rtl/relwin_match.sv
module relwin_match
    import relwin_pkg::*;
#(
    parameter logic [OFF_W-1:0] CTRL_OFF = '0,
    parameter logic [OFF_W-1:0] MBAR_OFF = OFF_W'(8)
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_ctrl_t         ctrl,
    output logic              hit,
    output logic [OFF_W-1:0]  offset,
    output regsel_e           sel
);
    logic [SEL_W-1:0] top_bits;

    always_comb begin
        top_bits = addr[ADDR_W-1 -: SEL_W];
        offset   = addr[OFF_W-1:0];
        hit      = ctrl.en && (top_bits == ctrl.base);
        if (!hit)
            sel = REG_NONE;
        else if (offset == CTRL_OFF)
            sel = REG_CTRL;
        else if (offset == MBAR_OFF)
            sel = REG_MBAR;
        else
            sel = REG_HOLE;
    end
endmodule

// File: rtl/relwin_regs.sv
module relwin_regs
    import relwin_pkg::*;
#(
    parameter logic [SEL_W-1:0]  RST_BASE = SEL_W'(1),
    parameter logic              RST_EN   = 1'b1,
    parameter logic [DATA_W-1:0] MBAR_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  regsel_e           sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output win_ctrl_t         ctrl,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mbar_q;
    logic              wr_ctrl;
    logic              wr_mbar;

    assign wr_ctrl = we && (sel == REG_CTRL);
    assign wr_mbar = we && (sel == REG_MBAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.base <= RST_BASE;
            ctrl.en   <= RST_EN;
        end else if (wr_ctrl) begin
            ctrl <= word_to_ctrl(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mbar_q <= MBAR_RST;
        else if (wr_mbar)
            mbar_q <= wdata;
    end

    always_comb begin
        unique case (sel)
            REG_CTRL: rdata = ctrl_to_word(ctrl);
            REG_MBAR: rdata = mbar_q;
            default:  rdata = '0;
        endcase
    end

    // R5
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl.base == $past(wdata[DATA_W-1 -: SEL_W])) && (ctrl.en == $past(wdata[0])));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_NONE || sel == REG_HOLE || !we) |=> $stable(ctrl) && $stable(mbar_q));

    // R7
    mbar_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mbar |=> mbar_q == $past(wdata));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_CTRL) |-> rdata[DATA_W-SEL_W-1:1] == '0);
endmodule

// File: rtl/relwin_top.sv
module relwin_top
    import relwin_pkg::*;
#(
    parameter logic [SEL_W-1:0]  RST_BASE = SEL_W'(1),
    parameter logic              RST_EN   = 1'b1,
    parameter logic [OFF_W-1:0]  MBAR_OFF = OFF_W'(8),
    parameter logic [DATA_W-1:0] MBAR_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              win_hit,
    output logic [29:0]       win_offset
);
    win_ctrl_t ctrl;
    regsel_e   sel;

    relwin_match #(
        .CTRL_OFF ('0),
        .MBAR_OFF (MBAR_OFF)
    ) u_match (
        .addr   (bus_addr),
        .ctrl   (ctrl),
        .hit    (win_hit),
        .offset (win_offset),
        .sel    (sel)
    );

    relwin_regs #(
        .RST_BASE (RST_BASE),
        .RST_EN   (RST_EN),
        .MBAR_RST (MBAR_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .ctrl  (ctrl),
        .rdata (bus_rdata)
    );

    // R6
    disable_kills_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (win_hit && bus_we && win_offset == '0 && !bus_wdata[0]) |=> !win_hit);

    // R8
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (win_hit && win_offset != '0 && win_offset != MBAR_OFF) |-> bus_rdata == '0);

    // R9
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> bus_rdata == '0);
endmodule

// File: tb/relwin_top_test.sv
module relwin_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        win_hit;
    logic [29:0] win_offset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    relwin_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_hit(win_hit), .win_offset(win_offset)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wd;
        logic        hit;
        logic [31:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h4000_0000, 1'b0, 32'h0, 1'b1, 32'h4000_0001, 8'd1},
        '{32'h4000_0008, 1'b0, 32'h0, 1'b1, 32'h0000_0000, 8'd1},
        '{32'h4000_0008, 1'b1, 32'h2000_0021, 1'b1, 32'h0000_0000, 8'd7},
        '{32'h4000_0008, 1'b0, 32'h0, 1'b1, 32'h2000_0021, 8'd7},
        '{32'h4000_0004, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'h0000_0000, 8'd8},
        '{32'h4000_0004, 1'b0, 32'h0, 1'b1, 32'h0000_0000, 8'd8},
        '{32'h0000_0000, 1'b1, 32'hC000_0001, 1'b0, 32'h0000_0000, 8'd9},
        '{32'h4000_0000, 1'b0, 32'h0, 1'b1, 32'h4000_0001, 8'd9},
        '{32'h4000_0008, 1'b0, 32'h0, 1'b1, 32'h2000_0021, 8'd8},
        '{32'h4000_0000, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h4000_0001, 8'd5},
        '{32'h4000_0000, 1'b0, 32'h0, 1'b0, 32'h0000_0000, 8'd5},
        '{32'hC000_0000, 1'b0, 32'h0, 1'b1, 32'hC000_0001, 8'd4},
        '{32'hC000_0008, 1'b0, 32'h0, 1'b1, 32'h2000_0021, 8'd7},
        '{32'hBFFF_FFFC, 1'b0, 32'h0, 1'b0, 32'h0000_0000, 8'd2},
        '{32'hC000_0000, 1'b1, 32'h8000_0000, 1'b1, 32'hC000_0001, 8'd6},
        '{32'hC000_0000, 1'b0, 32'h0, 1'b0, 32'h0000_0000, 8'd6},
        '{32'h8000_0000, 1'b1, 32'h8000_0001, 1'b0, 32'h0000_0000, 8'd6},
        '{32'h8000_0000, 1'b0, 32'h0, 1'b0, 32'h0000_0000, 8'd6}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = d;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Vector walk: reset decode, relocation, disable
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].we, VECS[i].wd);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d hit", i),
                  {31'b0, win_hit}, {31'b0, VECS[i].hit});
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d rdata", i),
                  bus_rdata, VECS[i].rd);
        end
        access(32'h0, 1'b0, 32'h0);

        // R6: every quarter misses while disabled
        for (int q = 0; q < 4; q++) begin
            access({q[1:0], 30'h0}, 1'b0, 32'h0);
            check("R6", "disabled quarter hit", {31'b0, win_hit}, 32'h0);
        end

        // R1: second reset restores defaults after relocation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(32'h4000_0000, 1'b0, 32'h0);
        check("R1", "ctrl after reset", bus_rdata, 32'h4000_0001);
        access(32'h4000_0008, 1'b0, 32'h0);
        check("R1", "mbar after reset", bus_rdata, 32'h0);

        // R3: offset at window top and middle
        access(32'h7FFF_FFFC, 1'b0, 32'h0);
        check("R3", "top offset", {2'b0, win_offset}, 32'h3FFF_FFFC);
        check("R2", "top hit", {31'b0, win_hit}, 32'h1);
        access(32'h4123_4567, 1'b0, 32'h0);
        check("R3", "mid offset", {2'b0, win_offset}, 32'h0123_4567);
        access(32'h8000_0000, 1'b0, 32'h0);
        check("R2", "next quarter miss", {31'b0, win_hit}, 32'h0);

        // R5: move window to quarter 0
        access(32'h4000_0000, 1'b1, 32'h0000_0001);
        access(32'h0000_0000, 1'b0, 32'h0);
        check("R5", "ctrl at base 0", bus_rdata, 32'h0000_0001);
        check("R5", "base 0 hit", {31'b0, win_hit}, 32'h1);
        access(32'h4000_0000, 1'b0, 32'h0);
        check("R5", "old base miss", {31'b0, win_hit}, 32'h0);
        access(32'h0000_0000, 1'b1, 32'h3FFF_FFFF);
        access(32'h0000_0000, 1'b0, 32'h0);
        check("R4", "reserved bits dropped", bus_rdata, 32'h0000_0001);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule